// File: doc/BRIEF.md
# Fractional Baud Tick Generator with Selectable Oversampling

This block produces the two timing strobes an asynchronous serial port needs: a sample strobe that paces the receive oversampler, and a bit strobe that marks each bit boundary for the transmitter. Both are derived from the system clock through a programmable divisor word. The upper field of the word is an integer count of clocks per sample. The low four bits are a fraction, in units of one sample count.

Software first forms the total divisor as the clock frequency divided by the baud rate, rounded to the nearest integer. It picks 8 samples per bit when that total is under 16, and 16 samples per bit otherwise. It then writes the total divided by the sample count into the upper field, and the remainder into the low field. The generator stretches individual sample periods by one clock whenever a fractional accumulator wraps. This makes one bit span exactly the programmed total divisor.

The divisor and the mode select are taken only while the enable is low. Raising the enable starts the generator afresh from a known phase.

Top module: `baud_frac_gen`

## Requirements
- R1: While rst_ni is low, smp_tick_o and bit_tick_o are 0, whatever the other inputs.
- R2: With os8_i=0, let M be div_i[15:4] and F be div_i[3:0]. A 4-bit accumulator starts at 0 on enable. Each sample period lasts M clocks, plus one clock when accumulator+F reaches 16. At the end of each period the accumulator becomes (accumulator+F) mod 16. A bit therefore spans 16*M+F clocks.
- R3: With os8_i=1, only div_i[2:0] is used as F, and div_i[3] has no effect. The accumulator wraps at 8, so a bit spans 8*M+F clocks.
- R4: div_i and os8_i are captured on every clock edge at which en_i is low. Changes to them while en_i stays high have no effect on either tick output.
- R5: If en_i is first sampled high at clock edge k, the first sample tick is registered at edge k+M-1 plus the first period's carry. smp_tick_o is high for the cycle after that edge.
- R6: bit_tick_o pulses together with every 16th sample tick (os8_i=0) or every 8th sample tick (os8_i=1), counted from the enable.
- R7: A clock edge with en_i low clears all counters and the accumulator. It also forces both tick outputs to 0 in the following cycle, so no ticks are produced while disabled.
- R8: A mantissa field of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Generator enable; configuration loads while low |
| div_i | input | 16 | Divisor word: [15:4] mantissa, [3:0] fraction |
| os8_i | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| smp_tick_o | output | 1 | One-cycle sample strobe |
| bit_tick_o | output | 1 | One-cycle bit strobe, coincident with a sample strobe |

## Verification
The assertions check several properties on every cycle:
- The captured configuration stays frozen while enabled.
- The accumulator and the sample index stay inside the 8x range in 8x mode.
- The period counter stays below the current period length.
- Every bit strobe lands on a sample strobe.
- Both strobes and the accumulator are quiet after a disabled cycle.

Only the bench's scenarios can show the exact placement of each stretched period and the resulting bit length of 16*M+F or 8*M+F. The same holds for the first-tick latency after enable, the clamping of a zero mantissa, and the fact that divisor writes during operation are ignored.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned FRAC_W = 4;
  localparam int unsigned OS16   = 1 << FRAC_W;
  localparam int unsigned OS8    = OS16 / 2;

  typedef enum logic {
    OS_X16 = 1'b0,
    OS_X8  = 1'b1
  } os_mode_e;
endpackage

// File: rtl/baud_cfg_latch.sv
module baud_cfg_latch
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  localparam int unsigned MANT_W = DIV_W - FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              os8_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [FRAC_W-1:0] frac_o,
  output os_mode_e          mode_o
);
  localparam logic [MANT_W-1:0] MANT_ONE = MANT_W'(1);

  logic [MANT_W-1:0] mant_q;
  logic [FRAC_W-1:0] frac_q;
  os_mode_e          mode_q;

  // load only while disabled; frozen during operation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_q <= MANT_ONE;
      frac_q <= '0;
      mode_q <= OS_X16;
    end else if (!en_i) begin
      mant_q <= div_i[DIV_W-1:FRAC_W];
      frac_q <= os8_i ? {1'b0, div_i[FRAC_W-2:0]} : div_i[FRAC_W-1:0];
      mode_q <= os8_i ? OS_X8 : OS_X16;
    end
  end

  assign mant_o = (mant_q == '0) ? MANT_ONE : mant_q;
  assign frac_o = frac_q;
  assign mode_o = mode_q;

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> ($stable(mant_q) && $stable(frac_q) && $stable(mode_q))); // R4
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc
  import baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  os_mode_e          mode_i,
  output logic              carry_o
);
  localparam logic [FRAC_W:0] OS8_V = (FRAC_W+1)'(OS8);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] acc_d;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, frac_i};
    if (mode_i == OS_X8) begin
      carry_o = (sum >= OS8_V);
      acc_d   = {1'b0, sum[FRAC_W-2:0]};
    end else begin
      carry_o = sum[FRAC_W];
      acc_d   = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (!en_i)   acc_q <= '0;
    else if (adv_i)   acc_q <= acc_d;
  end

  AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OS_X8) |-> (acc_q < FRAC_W'(OS8))); // R3
  AST_ACC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0)); // R7
endmodule

// File: rtl/baud_smp_cnt.sv
module baud_smp_cnt
  import baud_pkg::*;
#(
  parameter int unsigned MANT_W = 12,
  localparam int unsigned CNT_W = MANT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              carry_i,
  output logic              adv_o,
  output logic              smp_tick_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic             last;
  logic             tick_q;

  // period length: mantissa plus one stretch clock on accumulator wrap
  assign len   = {1'b0, mant_i} + (carry_i ? ONE : '0);
  assign last  = (cnt_q == (len - ONE));
  assign adv_o = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= last ? '0 : cnt_q + ONE;
      tick_q <= last;
    end
  end

  assign smp_tick_o = tick_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len); // R2
endmodule

// File: rtl/baud_bit_cnt.sv
module baud_bit_cnt
  import baud_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     adv_i,
  input  os_mode_e mode_i,
  input  logic     smp_tick_i,
  output logic     bit_tick_o
);
  localparam logic [FRAC_W-1:0] LAST16 = FRAC_W'(OS16 - 1);
  localparam logic [FRAC_W-1:0] LAST8  = FRAC_W'(OS8 - 1);
  localparam logic [FRAC_W-1:0] ONE    = FRAC_W'(1);

  logic [FRAC_W-1:0] sc_q;
  logic [FRAC_W-1:0] sc_last;
  logic              wrap;
  logic              bit_q;

  assign sc_last = (mode_i == OS_X8) ? LAST8 : LAST16;
  assign wrap    = adv_i && (sc_q == sc_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q  <= '0;
      bit_q <= 1'b0;
    end else if (!en_i) begin
      sc_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      if (adv_i) sc_q <= wrap ? '0 : sc_q + ONE;
      bit_q <= wrap;
    end
  end

  assign bit_tick_o = bit_q;

  AST_BIT_ON_SMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q |-> smp_tick_i); // R6
  AST_SC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OS_X8) |-> (sc_q < FRAC_W'(OS8))); // R6
  AST_BIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bit_q); // R7
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned MANT_W = DIV_W - FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             os8_i,
  output logic             smp_tick_o,
  output logic             bit_tick_o
);
  logic [MANT_W-1:0] mant;
  logic [FRAC_W-1:0] frac;
  os_mode_e          mode;
  logic              carry;
  logic              adv;
  logic              smp_tick;

  baud_cfg_latch #(.DIV_W(DIV_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_i),
    .os8_i  (os8_i),
    .mant_o (mant),
    .frac_o (frac),
    .mode_o (mode)
  );

  baud_frac_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .adv_i   (adv),
    .frac_i  (frac),
    .mode_i  (mode),
    .carry_o (carry)
  );

  baud_smp_cnt #(.MANT_W(MANT_W)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .mant_i     (mant),
    .carry_i    (carry),
    .adv_o      (adv),
    .smp_tick_o (smp_tick)
  );

  baud_bit_cnt u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .adv_i      (adv),
    .mode_i     (mode),
    .smp_tick_i (smp_tick),
    .bit_tick_o (bit_tick_o)
  );

  assign smp_tick_o = smp_tick;

  AST_SMP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !smp_tick_o); // R7
  AST_RESET_QUIET: assert final (rst_ni || (!smp_tick_o && !bit_tick_o)); // R1
endmodule

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             os8 = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic             smp, bitt;
  int               checks = 0;
  int               errors = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  baud_frac_gen #(.DIV_W(DIV_W)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .div_i      (div),
    .os8_i      (os8),
    .smp_tick_o (smp),
    .bit_tick_o (bitt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // disable, load config, enable, compare both strobes against a model
  task automatic run_case(input int m, input int f, input bit o8, input int nbits,
                          input string rs, input string rb, input bit chg);
    int me, osn, fe, acc, j, nxt, c, ncyc, smp_bad, bit_bad, first_s, first_b;
    int bt0, bt1, nb;
    @(negedge clk);
    en  = 1'b0;
    div = DIV_W'((m << 4) | f);
    os8 = o8;
    @(negedge clk);
    @(negedge clk);
    check(!smp && !bitt, "R7", "ticks while disabled", int'({smp, bitt}), 0);
    en = 1'b1;
    me  = (m == 0) ? 1 : m;
    osn = o8 ? 8 : 16;
    fe  = o8 ? (f & 7) : (f & 15);
    acc = 0; j = 0;
    c   = ((acc + fe) >= osn) ? 1 : 0;
    nxt = me + c - 1;
    acc = (acc + fe) % osn;
    ncyc = nbits * (osn * me + fe) + 4;
    smp_bad = 0; bit_bad = 0; first_s = -1; first_b = -1;
    bt0 = -1; bt1 = -1; nb = 0;
    for (int t = 0; t < ncyc; t++) begin
      bit es, eb;
      @(negedge clk);
      es = (t == nxt);
      eb = es && ((j % osn) == osn - 1);
      if (smp !== es) begin
        if (smp_bad == 0) first_s = t;
        smp_bad++;
      end
      if (bitt !== eb) begin
        if (bit_bad == 0) first_b = t;
        bit_bad++;
      end
      if (bitt === 1'b1) begin
        if (nb == 0) bt0 = t;
        else if (nb == 1) bt1 = t;
        nb++;
      end
      if (es) begin
        j++;
        c   = ((acc + fe) >= osn) ? 1 : 0;
        nxt = t + me + c;
        acc = (acc + fe) % osn;
      end
      if (chg && t == 20) begin
        div = 16'h0A5B;
        os8 = ~o8;
      end
    end
    check(smp_bad == 0, rs, $sformatf("sample tick mismatches (first at t=%0d)", first_s),
          smp_bad, 0);
    check(bit_bad == 0, rb, $sformatf("bit tick mismatches (first at t=%0d)", first_b),
          bit_bad, 0);
    if (nbits >= 2)
      check(bt1 - bt0 == osn * me + fe, rs, "bit period in clocks", bt1 - bt0, osn * me + fe);
  endtask

  task automatic t_reset();
    en  = 1'b1;
    div = 16'h0010;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!smp && !bitt, "R1", "ticks under reset", int'({smp, bitt}), 0);
    end
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) @(negedge clk);
    check(!smp && !bitt, "R7", "ticks after reset with enable low", int'({smp, bitt}), 0);
  endtask

  task automatic t_x16();
    run_case(3, 5, 1'b0, 3, "R2", "R6", 1'b0);
    run_case(4, 0, 1'b0, 3, "R2", "R6", 1'b0);
    run_case(1, 15, 1'b0, 3, "R2", "R6", 1'b0);
    run_case(2, 9, 1'b0, 3, "R2", "R6", 1'b0);
  endtask

  task automatic t_x8();
    run_case(2, 3, 1'b1, 3, "R3", "R6", 1'b0);
    run_case(3, 11, 1'b1, 3, "R3", "R6", 1'b0);  // bit 3 set, must not matter
    run_case(1, 7, 1'b1, 3, "R3", "R6", 1'b0);
  endtask

  task automatic t_zero_mant();
    run_case(0, 0, 1'b0, 2, "R8", "R8", 1'b0);
    run_case(0, 4, 1'b1, 2, "R8", "R8", 1'b0);
  endtask

  task automatic t_frozen();
    run_case(3, 2, 1'b0, 3, "R4", "R4", 1'b1);
  endtask

  task automatic t_restart();
    run_case(5, 7, 1'b0, 0, "R5", "R5", 1'b0);
    run_case(5, 7, 1'b0, 2, "R5", "R5", 1'b0);
    run_case(6, 13, 1'b0, 2, "R5", "R6", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all actual=200000 expected=fewer cycles");
    finish_run();
  end

  initial begin
    t_reset();
    t_x16();
    t_x8();
    t_zero_mant();
    t_frozen();
    t_restart();
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule